// File: doc/BRIEF.md
# Page Table Entry Fill Engine

This engine populates a single-level translation table for one physically contiguous region per command. It is given a starting virtual page, a starting physical frame number and a byte length. It walks the region in steps. At each step it picks the largest mapping size that the remaining length and the alignment of both page numbers allow. It then writes one 32-bit entry per 4 KB page through a simple write port, one entry per cycle. In clear mode it zeroes the same span of entries instead of mapping it.

After the entries are written, the engine can optionally run the translation-cache maintenance sequence. It first pulses a cache-flush request and waits for the cache's busy status to drop. It then pulses a TLB-clear request and waits for the clearing status to drop. Each wait is bounded by a cycle limit. The engine ends every command with a one-cycle done pulse that carries a status code.

The control state machine has the states IDLE, PICK, MAP, WIPE, KICK, DRAIN and DONE:
- IDLE to PICK or WIPE on a valid command.
- IDLE to DONE on a bad length or a zero length without maintenance.
- IDLE to KICK on a zero length with maintenance.
- PICK to MAP when the chunk fits; PICK to DONE on a frame overflow.
- MAP to PICK at the end of a chunk.
- MAP or WIPE to KICK or DONE at the end of the region.
- KICK to DRAIN, DRAIN to DONE when maintenance finishes, and DONE to IDLE.

The maintenance sequencer has the states F_IDLE, F_CGO, F_CWAIT, F_TGO, F_TWAIT and F_FIN. It runs them in that order. A wait that times out jumps straight to F_FIN.

Top module: `pte_fill_engine`

## Requirements
- R1: Each mapping entry is the word {flags[31:28], 4'b0, frame[23:0]}, written at mem_addr equal to its virtual page. Bit 29 (writable) and bit 28 (valid) are always set in a mapping entry.
- R2: A 1 MB step (256 entries, bit 31 set, bit 30 clear) is chosen when at least 256 pages remain and the low 8 bits of both the virtual page and the frame number are zero.
- R3: Otherwise a 64 KB step (16 entries, bit 30 set, bit 31 clear) is chosen when at least 16 pages remain and the low 4 bits of both values are zero.
- R4: Otherwise a single 4 KB entry is written with bits 31 and 30 both clear.
- R5: Within a region, successive entries go to successive virtual pages and carry frame numbers that increase by one. Every entry of a 1 MB or 64 KB step carries that step's size flag.
- R6: In clear mode the engine writes the value zero to length/4096 entries, starting at the given virtual page.
- R7: A length whose low 12 bits are not all zero ends the command with status 3, with no writes and no maintenance pulses.
- R8: If the frame number plus the chosen step's entry count would reach 2^24, that step is not written. The command ends with status 1 and no maintenance. Steps written before it remain.
- R9: With maintenance requested and no earlier error, the engine pulses cache_flush_go once. Only after cache_flushing is seen low does it pulse tlb_clear_go once, and it then waits for tlb_clearing to drop. Status 0 means success.
- R10: If a wait sees its busy input high for WAIT_LIMIT consecutive cycles, the command ends with status 2. A cache-flush timeout skips the TLB-clear step. A busy input that drops after WAIT_LIMIT-1 cycles does not time out.
- R11: A command is accepted only while cmd_ready is high (IDLE). cmd_valid at any other time is ignored. done is high for exactly one cycle, with done_status valid in that cycle.
- R12: After reset, cmd_ready is high and mem_we, done, cache_flush_go and tlb_clear_go are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request, taken when cmd_ready is high |
| cmd_clear | input | 1 | 1 selects clear mode (write zero entries) |
| cmd_flush | input | 1 | 1 runs the cache flush and TLB clear after the writes |
| cmd_vpn | input | VPN_W | Starting virtual page number |
| cmd_pfn | input | 24 | Starting physical frame number |
| cmd_len | input | LEN_W | Region length in bytes |
| cmd_ready | output | 1 | Engine idle, a command can be taken |
| mem_we | output | 1 | Table entry write strobe |
| mem_addr | output | VPN_W | Entry index (virtual page) |
| mem_wdata | output | 32 | Entry value |
| cache_flush_go | output | 1 | One-cycle request to flush the translation cache |
| cache_flushing | input | 1 | Translation cache flush in progress |
| tlb_clear_go | output | 1 | One-cycle request to clear the TLB |
| tlb_clearing | input | 1 | TLB clear in progress |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | 0 ok, 1 frame range error, 2 maintenance timeout, 3 bad length |

## Verification
The mapping function is driven with several kinds of region:
- A short misaligned run that may use only 4 KB entries.
- A region aligned for a superpage whose length adds a 64 KB tail and a single 4 KB tail.
- A region whose virtual page is superpage aligned but whose frame is only 16-page aligned, which separates a check of one value from a check of both.
- The reverse case, a frame that is aligned while the virtual page is off by one, which has to fall back to 4 KB entries.

Frame numbers next to 2^24 separate an overflow found on a 4 KB step, after earlier writes, from one found on a 64 KB step with nothing written. Busy times of WAIT_LIMIT-1 and WAIT_LIMIT cycles, and a stalled TLB clear, mark the edge of the timeout. A command offered while the engine is busy has to leave the write stream unchanged.

// File: rtl/pte_fill_pkg.sv
package pte_fill_pkg;

    // Entry word layout, fixed by the table consumer
    localparam int PAGE_SHIFT = 12;
    localparam int PFN_W      = 24;
    localparam int ENTRY_W    = 32;
    localparam int FLAG_W     = 4;
    localparam int PAD_W      = ENTRY_W - PFN_W - FLAG_W;
    localparam int SUPER_BIT  = 31;
    localparam int BIG_BIT    = 30;
    localparam int WR_BIT     = 29;
    localparam int VAL_BIT    = 28;

    // Step sizes, as log2 of the entry count
    localparam int SUPER_LOG2 = 8;
    localparam int BIG_LOG2   = 4;
    localparam int RUN_W      = SUPER_LOG2 + 1;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_RANGE   = 2'd1,
        ST_TIMEOUT = 2'd2,
        ST_LENGTH  = 2'd3
    } fill_status_e;

    typedef struct packed {
        logic super_f;
        logic big_f;
        logic wr_f;
        logic val_f;
    } pte_flags_t;

endpackage

// File: rtl/pte_size_sel.sv
module pte_size_sel
    import pte_fill_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int PG_W  = 20
) (
    input  logic [VPN_W-1:0] vpn,
    input  logic [PFN_W-1:0] pfn,
    input  logic [PG_W-1:0]  rem,
    output logic [RUN_W-1:0] npages,
    output pte_flags_t       flags,
    output logic             ovf
);
    localparam int SUPER_N = 1 << SUPER_LOG2;
    localparam int BIG_N   = 1 << BIG_LOG2;

    typedef enum logic [1:0] {CH_SMALL, CH_BIG, CH_SUPER} chunk_e;

    chunk_e          chunk;
    logic            super_ok;
    logic            big_ok;
    logic [PFN_W:0]  frame_end;

    // Both the virtual page and the frame must be aligned to the step
    assign super_ok = (rem >= PG_W'(SUPER_N))
                   && (vpn[SUPER_LOG2-1:0] == '0)
                   && (pfn[SUPER_LOG2-1:0] == '0);
    assign big_ok   = (rem >= PG_W'(BIG_N))
                   && (vpn[BIG_LOG2-1:0] == '0)
                   && (pfn[BIG_LOG2-1:0] == '0);

    always_comb begin
        if (super_ok) begin
            chunk  = CH_SUPER;
            npages = RUN_W'(SUPER_N);
        end else if (big_ok) begin
            chunk  = CH_BIG;
            npages = RUN_W'(BIG_N);
        end else begin
            chunk  = CH_SMALL;
            npages = RUN_W'(1);
        end
    end

    always_comb begin
        flags.super_f = (chunk == CH_SUPER);
        flags.big_f   = (chunk == CH_BIG);
        flags.wr_f    = 1'b1;
        flags.val_f   = 1'b1;
    end

    // The step overflows if its last frame plus one reaches 2^PFN_W
    assign frame_end = {1'b0, pfn} + (PFN_W+1)'(npages);
    assign ovf       = frame_end[PFN_W];

endmodule

// File: rtl/pte_flush_seq.sv
module pte_flush_seq #(
    parameter int WAIT_LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cache_flushing,
    input  logic tlb_clearing,
    output logic cache_flush_go,
    output logic tlb_clear_go,
    output logic finish,
    output logic timed_out
);
    localparam int CNT_W = $clog2(WAIT_LIMIT) + 1;

    typedef enum logic [2:0] {F_IDLE, F_CGO, F_CWAIT, F_TGO, F_TWAIT, F_FIN} fs_e;

    fs_e              st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             to_q, to_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= F_IDLE;
            cnt_q <= '0;
            to_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            to_q  <= to_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        to_d  = to_q;
        unique case (st_q)
            F_IDLE: begin
                if (start) begin
                    st_d = F_CGO;
                    to_d = 1'b0;
                end
            end
            F_CGO: begin
                st_d  = F_CWAIT;
                cnt_d = '0;
            end
            F_CWAIT: begin
                if (!cache_flushing) begin
                    st_d = F_TGO;
                end else if (cnt_q == CNT_W'(WAIT_LIMIT - 1)) begin
                    st_d = F_FIN;
                    to_d = 1'b1;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            F_TGO: begin
                st_d  = F_TWAIT;
                cnt_d = '0;
            end
            F_TWAIT: begin
                if (!tlb_clearing) begin
                    st_d = F_FIN;
                end else if (cnt_q == CNT_W'(WAIT_LIMIT - 1)) begin
                    st_d = F_FIN;
                    to_d = 1'b1;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            F_FIN:   st_d = F_IDLE;
            default: st_d = F_IDLE;
        endcase
    end

    always_comb begin
        cache_flush_go = (st_q == F_CGO);
        tlb_clear_go   = (st_q == F_TGO);
        finish         = (st_q == F_FIN);
        timed_out      = to_q;
    end

    // R9
    go_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cache_flush_go && tlb_clear_go));

    // R9
    tlb_after_cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_clear_go |-> ($past(st_q) == F_CWAIT) && !$past(cache_flushing));

    // R10
    timeout_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && timed_out) |-> $past(cache_flushing || tlb_clearing));

endmodule

// File: rtl/pte_fill_engine.sv
module pte_fill_engine
    import pte_fill_pkg::*;
#(
    parameter int VPN_W      = 20,
    parameter int LEN_W      = 32,
    parameter int WAIT_LIMIT = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic               cmd_clear,
    input  logic               cmd_flush,
    input  logic [VPN_W-1:0]   cmd_vpn,
    input  logic [PFN_W-1:0]   cmd_pfn,
    input  logic [LEN_W-1:0]   cmd_len,
    output logic               cmd_ready,
    output logic               mem_we,
    output logic [VPN_W-1:0]   mem_addr,
    output logic [ENTRY_W-1:0] mem_wdata,
    output logic               cache_flush_go,
    input  logic               cache_flushing,
    output logic               tlb_clear_go,
    input  logic               tlb_clearing,
    output logic               done,
    output logic [1:0]         done_status
);
    localparam int PG_W = LEN_W - PAGE_SHIFT;

    typedef enum logic [2:0] {S_IDLE, S_PICK, S_MAP, S_WIPE, S_KICK, S_DRAIN, S_DONE} state_e;

    state_e           st_q, st_d;
    logic [VPN_W-1:0] vpn_q, vpn_d;
    logic [PFN_W-1:0] pfn_q, pfn_d;
    logic [PG_W-1:0]  rem_q, rem_d;
    logic [RUN_W-1:0] run_q, run_d;
    pte_flags_t       flags_q, flags_d;
    logic             flush_q, flush_d;
    fill_status_e     stat_q, stat_d;

    logic [RUN_W-1:0] sel_pages;
    pte_flags_t       sel_flags;
    logic             sel_ovf;
    logic             fs_start;
    logic             fs_finish;
    logic             fs_timeout;

    pte_size_sel #(.VPN_W(VPN_W), .PG_W(PG_W)) u_size (
        .vpn    (vpn_q),
        .pfn    (pfn_q),
        .rem    (rem_q),
        .npages (sel_pages),
        .flags  (sel_flags),
        .ovf    (sel_ovf)
    );

    pte_flush_seq #(.WAIT_LIMIT(WAIT_LIMIT)) u_flush (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (fs_start),
        .cache_flushing (cache_flushing),
        .tlb_clearing   (tlb_clearing),
        .cache_flush_go (cache_flush_go),
        .tlb_clear_go   (tlb_clear_go),
        .finish         (fs_finish),
        .timed_out      (fs_timeout)
    );

    // State register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= S_IDLE;
            vpn_q   <= '0;
            pfn_q   <= '0;
            rem_q   <= '0;
            run_q   <= '0;
            flags_q <= '0;
            flush_q <= 1'b0;
            stat_q  <= ST_OK;
        end else begin
            st_q    <= st_d;
            vpn_q   <= vpn_d;
            pfn_q   <= pfn_d;
            rem_q   <= rem_d;
            run_q   <= run_d;
            flags_q <= flags_d;
            flush_q <= flush_d;
            stat_q  <= stat_d;
        end
    end

    // Next state and datapath updates
    always_comb begin
        st_d    = st_q;
        vpn_d   = vpn_q;
        pfn_d   = pfn_q;
        rem_d   = rem_q;
        run_d   = run_q;
        flags_d = flags_q;
        flush_d = flush_q;
        stat_d  = stat_q;
        unique case (st_q)
            S_IDLE: begin
                if (cmd_valid) begin
                    vpn_d   = cmd_vpn;
                    pfn_d   = cmd_pfn;
                    rem_d   = cmd_len[LEN_W-1:PAGE_SHIFT];
                    flush_d = cmd_flush;
                    stat_d  = ST_OK;
                    if (cmd_len[PAGE_SHIFT-1:0] != '0) begin
                        stat_d = ST_LENGTH;
                        st_d   = S_DONE;
                    end else if (cmd_len[LEN_W-1:PAGE_SHIFT] == '0) begin
                        st_d = cmd_flush ? S_KICK : S_DONE;
                    end else begin
                        st_d = cmd_clear ? S_WIPE : S_PICK;
                    end
                end
            end
            S_PICK: begin
                if (sel_ovf) begin
                    stat_d = ST_RANGE;
                    st_d   = S_DONE;
                end else begin
                    run_d   = sel_pages;
                    flags_d = sel_flags;
                    st_d    = S_MAP;
                end
            end
            S_MAP: begin
                vpn_d = vpn_q + VPN_W'(1);
                pfn_d = pfn_q + PFN_W'(1);
                rem_d = rem_q - PG_W'(1);
                run_d = run_q - RUN_W'(1);
                if (rem_q == PG_W'(1)) begin
                    st_d = flush_q ? S_KICK : S_DONE;
                end else if (run_q == RUN_W'(1)) begin
                    st_d = S_PICK;
                end
            end
            S_WIPE: begin
                vpn_d = vpn_q + VPN_W'(1);
                rem_d = rem_q - PG_W'(1);
                if (rem_q == PG_W'(1)) begin
                    st_d = flush_q ? S_KICK : S_DONE;
                end
            end
            S_KICK:  st_d = S_DRAIN;
            S_DRAIN: begin
                if (fs_finish) begin
                    stat_d = fs_timeout ? ST_TIMEOUT : ST_OK;
                    st_d   = S_DONE;
                end
            end
            S_DONE:  st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        cmd_ready   = (st_q == S_IDLE);
        mem_we      = (st_q == S_MAP) || (st_q == S_WIPE);
        mem_addr    = vpn_q;
        mem_wdata   = (st_q == S_MAP) ? {flags_q, {PAD_W{1'b0}}, pfn_q} : '0;
        fs_start    = (st_q == S_KICK);
        done        = (st_q == S_DONE);
        done_status = stat_q;
    end

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !mem_we && !done);

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> mem_addr == VPN_W'($past(mem_addr) + VPN_W'(1)));

    // R1
    mapped_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_wdata != '0) |-> mem_wdata[WR_BIT] && mem_wdata[VAL_BIT]);

    // R2
    super_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_wdata[SUPER_BIT]) |->
            mem_addr[SUPER_LOG2-1:0] == mem_wdata[SUPER_LOG2-1:0] && !mem_wdata[BIG_BIT]);

    // R3
    big_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_wdata[BIG_BIT]) |->
            mem_addr[BIG_LOG2-1:0] == mem_wdata[BIG_LOG2-1:0]);

    // R7
    bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && cmd_valid && cmd_len[PAGE_SHIFT-1:0] != '0) |=> done && !mem_we);

endmodule

// File: tb/pte_fill_engine_test.sv
module pte_fill_engine_test;
    import pte_fill_pkg::*;

    localparam int VPN_W = 20;
    localparam int LEN_W = 32;
    localparam int LIMIT = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic              cmd_valid = 1'b0;
    logic              cmd_clear = 1'b0;
    logic              cmd_flush = 1'b0;
    logic [VPN_W-1:0]  cmd_vpn = '0;
    logic [23:0]       cmd_pfn = '0;
    logic [LEN_W-1:0]  cmd_len = '0;
    logic              cmd_ready, mem_we, cache_flush_go, tlb_clear_go, done;
    logic [VPN_W-1:0]  mem_addr;
    logic [31:0]       mem_wdata;
    logic [1:0]        done_status;
    logic              cache_flushing, tlb_clearing;

    pte_fill_engine #(.VPN_W(VPN_W), .LEN_W(LEN_W), .WAIT_LIMIT(LIMIT)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_clear(cmd_clear),
        .cmd_flush(cmd_flush), .cmd_vpn(cmd_vpn), .cmd_pfn(cmd_pfn), .cmd_len(cmd_len),
        .cmd_ready(cmd_ready), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cache_flush_go(cache_flush_go), .cache_flushing(cache_flushing),
        .tlb_clear_go(tlb_clear_go), .tlb_clearing(tlb_clearing),
        .done(done), .done_status(done_status)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Cache and TLB models: busy for a set number of cycles after each request
    int cache_len = 2;
    int tlb_len = 2;
    int cache_cnt = 0;
    int tlb_cnt = 0;
    always @(posedge clk) begin
        if (cache_flush_go) cache_cnt <= cache_len;
        else if (cache_cnt > 0) cache_cnt <= cache_cnt - 1;
        if (tlb_clear_go) tlb_cnt <= tlb_len;
        else if (tlb_cnt > 0) tlb_cnt <= tlb_cnt - 1;
    end
    assign cache_flushing = (cache_cnt != 0);
    assign tlb_clearing   = (tlb_cnt != 0);

    // Scoreboard
    typedef struct {
        logic [VPN_W-1:0] a;
        logic [31:0]      d;
        string            tag;
    } exp_t;
    exp_t exp_q[$];

    int         n_cache = 0;
    int         n_tlb = 0;
    bit         got_done = 1'b0;
    logic [1:0] got_status = 2'd0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 R11 unexpected write", 32'(mem_addr), 32'hFFFFFFFF);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(mem_addr == e.a, {e.tag, " entry address"}, 32'(mem_addr), 32'(e.a));
                    check(mem_wdata == e.d, {e.tag, " entry value"}, mem_wdata, e.d);
                end
            end
            if (cache_flush_go) n_cache++;
            if (tlb_clear_go) begin
                n_tlb++;
                check(n_cache == n_tlb && !cache_flushing, "R9 TLB clear after cache flush",
                      32'(n_cache), 32'(n_tlb));
            end
            if (done) begin
                got_done   = 1'b1;
                got_status = done_status;
            end
        end
    end

    // Reference model of the table fill, from the requirements
    task automatic build_expect(input bit clr, input int v0, input int p0, input int pages);
        int v = v0;
        int p = p0;
        int left = pages;
        int n;
        logic [3:0] fl;
        string tg;
        exp_t e;
        if (clr) begin
            for (int i = 0; i < pages; i++) begin
                e.a = VPN_W'(v0 + i);
                e.d = 32'h0;
                e.tag = "R6";
                exp_q.push_back(e);
            end
            return;
        end
        while (left > 0) begin
            if (left >= 256 && (v % 256) == 0 && (p % 256) == 0) begin
                n = 256; fl = 4'b1011; tg = "R1 R2 R5";
            end else if (left >= 16 && (v % 16) == 0 && (p % 16) == 0) begin
                n = 16; fl = 4'b0111; tg = "R1 R3 R5";
            end else begin
                n = 1; fl = 4'b0011; tg = "R1 R4";
            end
            if (p + n >= (1 << 24)) break;
            for (int i = 0; i < n; i++) begin
                e.a = VPN_W'(v + i);
                e.d = {fl, 4'b0000, 24'(p + i)};
                e.tag = tg;
                exp_q.push_back(e);
            end
            v += n;
            p += n;
            left -= n;
        end
    endtask

    task automatic run_cmd(input bit clr, input bit fl, input int v, input int p,
                           input logic [31:0] len, input int exp_st, input int exp_c,
                           input int exp_t_n, input string tag, input bit poke);
        int n = 0;
        n_cache = 0;
        n_tlb = 0;
        got_done = 1'b0;
        if (len[11:0] == 12'h0) build_expect(clr, v, p, int'(len >> 12));
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_clear = clr;
        cmd_flush = fl;
        cmd_vpn = VPN_W'(v);
        cmd_pfn = 24'(p);
        cmd_len = len;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            check(cmd_ready == 1'b0, "R11 ready low while busy", 32'(cmd_ready), 32'h0);
            cmd_valid = 1'b1;
            cmd_clear = 1'b1;
            cmd_vpn = 20'hAAAAA;
            cmd_len = 32'h5000;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        while (!got_done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(got_done, {tag, " done seen"}, 32'(got_done), 32'h1);
        @(negedge clk);
        check(done == 1'b0, "R11 done lasts one cycle", 32'(done), 32'h0);
        check(got_status == 2'(exp_st), {tag, " status"}, 32'(got_status), 32'(exp_st));
        check(exp_q.size() == 0, {tag, " all entries written"}, 32'(exp_q.size()), 32'h0);
        check(n_cache == exp_c, {tag, " cache flush pulses"}, 32'(n_cache), 32'(exp_c));
        check(n_tlb == exp_t_n, {tag, " TLB clear pulses"}, 32'(n_tlb), 32'(exp_t_n));
        exp_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(cmd_ready == 1'b1, "R12 ready after reset", 32'(cmd_ready), 32'h1);
        check(!mem_we && !done, "R12 no write or done after reset", 32'({mem_we, done}), 32'h0);
        check(!cache_flush_go && !tlb_clear_go, "R12 no requests after reset",
              32'({cache_flush_go, tlb_clear_go}), 32'h0);

        // R4 misaligned short run
        run_cmd(1'b0, 1'b0, 3, 5, 32'h3000, 0, 0, 0, "R4 small run", 1'b0);
        // R2 R3 R4 R9 superpage, bigpage and small tail with maintenance
        cache_len = 3; tlb_len = 2;
        run_cmd(1'b0, 1'b1, 'h100, 'h200, 32'h111000, 0, 1, 1, "R2 R3 R9 mixed", 1'b0);
        // R3 virtual page aligned for a superpage, frame only for a bigpage
        run_cmd(1'b0, 1'b0, 'h200, 'h10, 32'h100000, 0, 0, 0, "R3 frame misaligned", 1'b0);
        // R4 frame aligned, virtual page off by one
        run_cmd(1'b0, 1'b0, 'h301, 'h400, 32'h10000, 0, 0, 0, "R4 vpn misaligned", 1'b0);
        // R7 bad length
        run_cmd(1'b0, 1'b1, 'h10, 'h10, 32'h1800, 3, 0, 0, "R7 bad length", 1'b0);
        // R8 overflow on the second small step
        run_cmd(1'b0, 1'b1, 'h20, 'hFFFFFE, 32'h2000, 1, 0, 0, "R8 small overflow", 1'b0);
        // R8 overflow on a bigpage step, nothing written
        run_cmd(1'b0, 1'b0, 'h10, 'hFFFFF0, 32'h10000, 1, 0, 0, "R8 big overflow", 1'b0);
        // R6 R10 clear mode, cache busy one cycle short of the limit
        cache_len = LIMIT - 1; tlb_len = 1;
        run_cmd(1'b1, 1'b1, 'h40, 0, 32'h5000, 0, 1, 1, "R6 R10 clear edge", 1'b0);
        // R10 cache busy for the full limit
        cache_len = LIMIT; tlb_len = 1;
        run_cmd(1'b0, 1'b1, 'h50, 'h60, 32'h1000, 2, 1, 0, "R10 cache timeout", 1'b0);
        // R10 TLB clear stalls
        cache_len = 2; tlb_len = 100;
        run_cmd(1'b0, 1'b1, 'h51, 'h61, 32'h1000, 2, 1, 1, "R10 tlb timeout", 1'b0);
        repeat (100) @(negedge clk);
        // zero length without maintenance
        run_cmd(1'b0, 1'b0, 'h60, 'h60, 32'h0, 0, 0, 0, "R11 empty region", 1'b0);
        // R11 command offered while busy is ignored
        cache_len = 1; tlb_len = 1;
        run_cmd(1'b0, 1'b1, 'h1000, 'h3000, 32'h20000, 0, 1, 1, "R11 busy ignore", 1'b1);
        repeat (5) @(negedge clk);
        check(!mem_we && cmd_ready, "R11 idle after ignored command",
              32'({mem_we, cmd_ready}), 32'h1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule